// File: doc/BRIEF.md
# Machine-Level Trap Controller

This block keeps the machine-level trap state of a single-hart, 32-bit core. That state covers the global interrupt enable and its saved copy, the saved privilege, and the per-source interrupt enables. It also holds the handler base address, the return address, the trap cause, the trap detail value and a scratch word. The pipeline presents an exception request with a 4-bit cause code, the PC of the faulting instruction and a fault address. Three interrupt lines (software, timer, external) come from outside. The block decides in the same cycle whether a trap is taken, drives a redirect PC, and updates its state on the next clock edge. A return request restores the saved state and redirects to the saved return address.

Software reaches the registers through a single-cycle CSR port. That port follows valid/ready rules. A request is accepted on a clock edge where both `csr_valid` and `csr_ready` are high. The read data is combinational and valid while `csr_valid` is high. `csr_ready` drops in any cycle where a trap or a return is being taken. In such a cycle a write is not applied, and the requester must hold the request and present it again. Redirect, privilege and interrupt lines are plain level signals.

Top module: `mtrap_unit`

## Requirements
- R1: When a trap is taken, `redirect_valid` is 1 and `redirect_pc` equals the handler base register in the same cycle. The base register (address 0x305) ignores writes to bits 1:0, which always read 0.
- R2: On an exception the return-address register (0x341) receives `exc_pc`. On an interrupt it receives `next_pc`.
- R3: On trap entry the status register (0x300) copies its enable bit (bit 3) into its saved-enable bit (bit 7) and clears bit 3.
- R4: On trap entry the privilege in effect (U=00, M=11) is stored in status bits 12:11, and `priv_mode` becomes 11.
- R5: On a return request with no trap in the same cycle, `redirect_pc` equals the return-address register. At the following edge bit 3 takes the value of bit 7, bit 7 becomes 1, `priv_mode` takes the value of bits 12:11, and bits 12:11 become 00.
- R6: The detail register (0x343) receives `exc_tval` for causes 0, 4, 5, 6, 7, 13 and 15. It receives `exc_pc` for causes 1, 2, 3 and 12. It receives zero for causes 8, 9, 10, 11 and 14 and for every interrupt.
- R7: Exceptions are taken regardless of any enable. An interrupt is taken only when status bit 3 is 1 and its enable bit (0x304) is set.
- R8: The cause register (0x342) holds the exception code with bit 31 clear. For interrupts it holds bit 31 set with code 3 (software), 7 (timer) or 11 (external). These same bit positions are used in the enable and pending (0x344) registers.
- R9: Priority is exception over interrupt over return. Among interrupts the order is external, then software, then timer.
- R10: The pending register reflects the input lines and ignores writes. Only bits 3, 7 and 11 of the enable register are writable. The scratch register (0x340) stores any 32-bit value. Unmapped addresses read 0.
- R11: `csr_ready` is 0 in any cycle in which a trap or a return is taken, and a write offered in that cycle has no effect.
- R12: After reset, status reads 0x1800, `priv_mode` is 11, the handler base is `RESET_VEC`, and the enable, scratch, return-address, cause and detail registers read 0.
- R13: A status write whose bits 12:11 are 01 or 10 leaves the saved privilege unchanged; the other fields still update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request this cycle |
| exc_cause | input | 4 | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_tval | input | 32 | Faulting address for address-bearing causes |
| next_pc | input | 32 | PC of the next instruction, saved on interrupts |
| irq_sw | input | 1 | Software interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| mret_req | input | 1 | Trap-return request |
| csr_valid | input | 1 | CSR request valid |
| csr_ready | output | 1 | CSR request accepted this cycle |
| csr_we | input | 1 | CSR request is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| redirect_valid | output | 1 | Fetch must redirect this cycle |
| redirect_pc | output | 32 | Redirect target |
| priv_mode | output | 2 | Current privilege (00 user, 11 machine) |

## Verification
The hardest situation to reach is a collision in a single cycle: an exception, a pending and enabled interrupt, a return request and a CSR write all offered at once. Each of these arrives on a separate port and only the arbitration decides which one wins. The bench drives these together at chosen points. It first walks the status register into user privilege through two successive returns, then raises an exception alongside the external line, and later an exception alongside a return and alongside a scratch write. It then reads the saved cause, privilege and scratch value back over the CSR port to show which request won.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_ENABLE  = 12'h304;
  localparam logic [11:0] A_VECTOR  = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_DETAIL  = 12'h343;
  localparam logic [11:0] A_PENDING = 12'h344;

  localparam int ST_IE   = 3;
  localparam int ST_PIE  = 7;
  localparam int ST_PPLO = 11;

  localparam int NUM_IRQ = 3;
  localparam int IRQ_SW  = 3;
  localparam int IRQ_TMR = 7;
  localparam int IRQ_EXT = 11;

  typedef enum logic [1:0] {TV_ZERO, TV_ADDR, TV_PC} tval_src_e;

  function automatic int irq_pos(input int idx);
    case (idx)
      0:       return IRQ_SW;
      1:       return IRQ_TMR;
      default: return IRQ_EXT;
    endcase
  endfunction

  function automatic tval_src_e tval_src(input logic [3:0] cause);
    case (cause)
      4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd13, 4'd15: return TV_ADDR;
      4'd1, 4'd2, 4'd3, 4'd12:                    return TV_PC;
      default:                                    return TV_ZERO;
    endcase
  endfunction

  function automatic logic priv_legal(input logic [1:0] p);
    return (p == PRIV_U) || (p == PRIV_M);
  endfunction

endpackage

// File: rtl/mtrap_select.sv
module mtrap_select
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [3:0]      exc_cause,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_tval,
  input  logic [XLEN-1:0] next_pc,
  input  logic [XLEN-1:0] pend_vec,
  input  logic [XLEN-1:0] en_vec,
  input  logic            glb_ie,
  input  logic            mret_req,
  output logic            take_trap,
  output logic            take_ret,
  output logic            trap_irq,
  output logic [3:0]      trap_code,
  output logic [XLEN-1:0] trap_tval,
  output logic [XLEN-1:0] trap_epc
);

  logic [XLEN-1:0] armed;
  logic            irq_go;
  logic [3:0]      irq_code;

  assign armed  = pend_vec & en_vec;
  assign irq_go = glb_ie && (armed != '0);

  always_comb begin
    if (armed[IRQ_EXT])     irq_code = 4'(IRQ_EXT);
    else if (armed[IRQ_SW]) irq_code = 4'(IRQ_SW);
    else                    irq_code = 4'(IRQ_TMR);
  end

  assign take_trap = exc_valid || irq_go;
  assign take_ret  = mret_req && !take_trap;
  assign trap_irq  = !exc_valid;
  assign trap_code = exc_valid ? exc_cause : irq_code;
  assign trap_epc  = exc_valid ? exc_pc : next_pc;

  always_comb begin
    trap_tval = '0;
    if (exc_valid) begin
      case (tval_src(exc_cause))
        TV_ADDR: trap_tval = exc_tval;
        TV_PC:   trap_tval = exc_pc;
        default: trap_tval = '0;
      endcase
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && trap_irq) |-> (glb_ie && pend_vec[trap_code] && en_vec[trap_code])); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_trap && take_ret)); // R9
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && trap_irq && pend_vec[IRQ_EXT] && en_vec[IRQ_EXT]) |-> (trap_code == 4'(IRQ_EXT))); // R9

endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
  import mtrap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_trap,
  input  logic            take_ret,
  input  logic            trap_irq,
  input  logic [3:0]      trap_code,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic            wr_en,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] vec_base,
  output logic [XLEN-1:0] ret_pc,
  output logic [XLEN-1:0] pend_vec,
  output logic [XLEN-1:0] en_vec,
  output logic            glb_ie,
  output logic [1:0]      priv
);

  localparam int CODE_PAD = XLEN - 5;

  function automatic logic [XLEN-1:0] en_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_IRQ; i++) m[irq_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] EN_MASK = en_mask();

  logic            ie_q, pie_q;
  logic [1:0]      pp_q, priv_q;
  logic [XLEN-1:0] en_q, epc_q, cause_q, detail_q, scratch_q;
  logic [XLEN-3:0] base_q;
  logic [XLEN-1:0] status_w;

  always_comb begin
    pend_vec = '0;
    for (int i = 0; i < NUM_IRQ; i++) pend_vec[irq_pos(i)] = irq_lines[i];
  end

  always_comb begin
    status_w = '0;
    status_w[ST_IE]            = ie_q;
    status_w[ST_PIE]           = pie_q;
    status_w[ST_PPLO+1:ST_PPLO] = pp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      pie_q     <= 1'b0;
      pp_q      <= PRIV_M;
      priv_q    <= PRIV_M;
      en_q      <= '0;
      base_q    <= RESET_VEC[XLEN-1:2];
      epc_q     <= '0;
      cause_q   <= '0;
      detail_q  <= '0;
      scratch_q <= '0;
    end else if (take_trap) begin
      epc_q    <= trap_epc;
      cause_q  <= {trap_irq, {CODE_PAD{1'b0}}, trap_code};
      detail_q <= trap_tval;
      pie_q    <= ie_q;
      ie_q     <= 1'b0;
      pp_q     <= priv_q;
      priv_q   <= PRIV_M;
    end else if (take_ret) begin
      ie_q   <= pie_q;
      pie_q  <= 1'b1;
      priv_q <= pp_q;
      pp_q   <= PRIV_U;
    end else if (wr_en) begin
      case (addr)
        A_STATUS: begin
          ie_q  <= wdata[ST_IE];
          pie_q <= wdata[ST_PIE];
          if (priv_legal(wdata[ST_PPLO+1:ST_PPLO])) pp_q <= wdata[ST_PPLO+1:ST_PPLO];
        end
        A_ENABLE:  en_q      <= wdata & EN_MASK;
        A_VECTOR:  base_q    <= wdata[XLEN-1:2];
        A_SCRATCH: scratch_q <= wdata;
        A_EPC:     epc_q     <= wdata;
        A_CAUSE:   cause_q   <= wdata;
        A_DETAIL:  detail_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_STATUS:  rdata = status_w;
      A_ENABLE:  rdata = en_q;
      A_VECTOR:  rdata = {base_q, 2'b00};
      A_SCRATCH: rdata = scratch_q;
      A_EPC:     rdata = epc_q;
      A_CAUSE:   rdata = cause_q;
      A_DETAIL:  rdata = detail_q;
      A_PENDING: rdata = pend_vec;
      default:   rdata = '0;
    endcase
  end

  assign vec_base = {base_q, 2'b00};
  assign ret_pc   = epc_q;
  assign en_vec   = en_q;
  assign glb_ie   = ie_q;
  assign priv     = priv_q;

  AST_ENTRY_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (!ie_q && pie_q == $past(ie_q))); // R3
  AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (priv_q == PRIV_M && pp_q == $past(priv_q))); // R4
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> (ie_q == $past(pie_q) && pie_q && priv_q == $past(pp_q) && pp_q == PRIV_U)); // R5
  AST_IRQ_DETAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && trap_irq) |=> (detail_q == '0 && cause_q[XLEN-1])); // R6
  AST_PP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    priv_legal(pp_q) && priv_legal(priv_q)); // R13
  AST_SCRATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(scratch_q)); // R11

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [3:0]      exc_cause,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_tval,
  input  logic [XLEN-1:0] next_pc,
  input  logic            irq_sw,
  input  logic            irq_tmr,
  input  logic            irq_ext,
  input  logic            mret_req,
  input  logic            csr_valid,
  output logic            csr_ready,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      priv_mode
);

  logic            take_trap, take_ret, trap_irq, glb_ie, wr_en;
  logic [3:0]      trap_code;
  logic [XLEN-1:0] trap_tval, trap_epc, vec_base, ret_pc, pend_vec, en_vec;

  mtrap_select #(.XLEN(XLEN)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .exc_pc    (exc_pc),
    .exc_tval  (exc_tval),
    .next_pc   (next_pc),
    .pend_vec  (pend_vec),
    .en_vec    (en_vec),
    .glb_ie    (glb_ie),
    .mret_req  (mret_req),
    .take_trap (take_trap),
    .take_ret  (take_ret),
    .trap_irq  (trap_irq),
    .trap_code (trap_code),
    .trap_tval (trap_tval),
    .trap_epc  (trap_epc)
  );

  assign csr_ready = !(take_trap || take_ret);
  assign wr_en     = csr_valid && csr_ready && csr_we;

  mtrap_csr_file #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_trap (take_trap),
    .take_ret  (take_ret),
    .trap_irq  (trap_irq),
    .trap_code (trap_code),
    .trap_tval (trap_tval),
    .trap_epc  (trap_epc),
    .irq_lines ({irq_ext, irq_tmr, irq_sw}),
    .wr_en     (wr_en),
    .addr      (csr_addr),
    .wdata     (csr_wdata),
    .rdata     (csr_rdata),
    .vec_base  (vec_base),
    .ret_pc    (ret_pc),
    .pend_vec  (pend_vec),
    .en_vec    (en_vec),
    .glb_ie    (glb_ie),
    .priv      (priv_mode)
  );

  assign redirect_valid = take_trap || take_ret;
  assign redirect_pc    = take_trap ? vec_base : ret_pc;

  AST_EXC_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (ret_pc == $past(exc_pc))); // R2
  AST_IRQ_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && !exc_valid) |=> (ret_pc == $past(next_pc))); // R2
  AST_EXC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (redirect_valid && !csr_ready)); // R7
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid && exc_valid |-> (redirect_pc[1:0] == 2'b00)); // R1

endmodule

// File: tb/mtrap_unit_test.sv
module mtrap_unit_test;
  import mtrap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_cause = '0;
  logic [31:0] exc_pc = '0, exc_tval = '0, next_pc = '0;
  logic        irq_sw = 1'b0, irq_tmr = 1'b0, irq_ext = 1'b0, mret_req = 1'b0;
  logic        csr_valid = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_ready, redirect_valid;
  logic [31:0] csr_rdata, redirect_pc;
  logic [1:0]  priv_mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mtrap_unit uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_pc(exc_pc), .exc_tval(exc_tval), .next_pc(next_pc),
    .irq_sw(irq_sw), .irq_tmr(irq_tmr), .irq_ext(irq_ext), .mret_req(mret_req),
    .csr_valid(csr_valid), .csr_ready(csr_ready), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .priv_mode(priv_mode)
  );

  // cause code and detail source: 0 zero, 1 fault address, 2 instruction PC
  localparam logic [5:0] EXC_TAB [16] = '{
    {4'd0, 2'd1}, {4'd1, 2'd2}, {4'd2, 2'd2}, {4'd3, 2'd2},
    {4'd4, 2'd1}, {4'd5, 2'd1}, {4'd6, 2'd1}, {4'd7, 2'd1},
    {4'd8, 2'd0}, {4'd9, 2'd0}, {4'd10, 2'd0}, {4'd11, 2'd0},
    {4'd12, 2'd2}, {4'd13, 2'd1}, {4'd14, 2'd0}, {4'd15, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1 d = csr_rdata;
    csr_valid = 1'b0;
  endtask

  task automatic do_ret(input string tag, input logic [31:0] exp_pc);
    @(negedge clk);
    mret_req = 1'b1;
    #1 chk({tag, " return redirect"}, redirect_pc, exp_pc);
    @(negedge clk);
    mret_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    csr_rd(A_STATUS, v);  chk("R12 status", v, 32'h1800);
    csr_rd(A_VECTOR, v);  chk("R12 vector", v, 32'h100);
    csr_rd(A_ENABLE, v);  chk("R12 enable", v, 0);
    csr_rd(A_SCRATCH, v); chk("R12 scratch", v, 0);
    csr_rd(A_CAUSE, v);   chk("R12 cause", v, 0);
    chk("R12 priv", {30'd0, priv_mode}, 3);
    chk("R12 no redirect", {31'd0, redirect_valid}, 0);

    // R1 base alignment
    csr_wr(A_VECTOR, 32'h0000_2003);
    csr_rd(A_VECTOR, v); chk("R1 vector low bits", v, 32'h2000);

    // table walk: every cause code, R1 R2 R6 R7 R8
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pc, ta, expd;
      pc = 32'h1000 + 32'(i) * 4;
      ta = 32'hA000 + 32'(i);
      expd = (EXC_TAB[i][1:0] == 2'd1) ? ta : (EXC_TAB[i][1:0] == 2'd2) ? pc : 32'h0;
      @(negedge clk);
      exc_valid = 1'b1; exc_cause = EXC_TAB[i][5:2]; exc_pc = pc; exc_tval = ta;
      next_pc = pc + 4;
      #1;
      chk("R7 exception taken", {31'd0, redirect_valid}, 1);
      chk("R1 redirect to base", redirect_pc, 32'h2000);
      @(negedge clk);
      exc_valid = 1'b0;
      csr_rd(A_CAUSE, v);  chk("R8 exception cause", v, {28'd0, EXC_TAB[i][5:2]});
      csr_rd(A_DETAIL, v); chk("R6 exception detail", v, expd);
      csr_rd(A_EPC, v);    chk("R2 exception epc", v, pc);
    end

    // R10 enable/pending register behaviour
    csr_wr(A_ENABLE, 32'hFFFF_FFFF);
    csr_rd(A_ENABLE, v); chk("R10 enable writable bits", v, 32'h888);
    @(negedge clk); irq_tmr = 1'b1;
    #1 chk("R7 masked by global enable", {31'd0, redirect_valid}, 0);
    csr_rd(A_PENDING, v); chk("R10 pending follows line", v, 32'h80);
    csr_wr(A_PENDING, 32'h0);
    csr_rd(A_PENDING, v); chk("R10 pending ignores write", v, 32'h80);
    @(negedge clk); irq_tmr = 1'b0;

    // timer interrupt taken: R2 R3 R4 R6 R8
    csr_wr(A_STATUS, 32'h0000_1808);
    @(negedge clk); irq_tmr = 1'b1; next_pc = 32'h3004; exc_pc = 32'h3000;
    #1 chk("R7 timer taken", {31'd0, redirect_valid}, 1);
    chk("R1 irq redirect", redirect_pc, 32'h2000);
    @(negedge clk); irq_tmr = 1'b0;
    csr_rd(A_CAUSE, v);  chk("R8 timer cause", v, 32'h8000_0007);
    csr_rd(A_DETAIL, v); chk("R6 irq detail zero", v, 0);
    csr_rd(A_EPC, v);    chk("R2 irq epc next", v, 32'h3004);
    csr_rd(A_STATUS, v); chk("R3 R4 status after entry", v, 32'h1880);

    // R5 returns
    do_ret("R5 first", 32'h3004);
    csr_rd(A_STATUS, v); chk("R5 status after return", v, 32'h0088);
    chk("R5 priv from saved M", {30'd0, priv_mode}, 3);
    do_ret("R5 second", 32'h3004);
    chk("R5 priv from saved U", {30'd0, priv_mode}, 0);

    // R9 exception beats interrupt, R4 from user
    @(negedge clk); exc_valid = 1'b1; exc_cause = 4'd8; exc_pc = 32'h4000; irq_ext = 1'b1;
    @(negedge clk); exc_valid = 1'b0; irq_ext = 1'b0;
    csr_rd(A_CAUSE, v);  chk("R9 exception over irq", v, 32'd8);
    csr_rd(A_STATUS, v); chk("R4 saved user priv", v, 32'h0080);
    chk("R4 priv now machine", {30'd0, priv_mode}, 3);

    // R9 interrupt order
    csr_wr(A_STATUS, 32'h0000_1808);
    @(negedge clk); irq_sw = 1'b1; irq_tmr = 1'b1; irq_ext = 1'b1;
    @(negedge clk); irq_sw = 1'b0; irq_tmr = 1'b0; irq_ext = 1'b0;
    csr_rd(A_CAUSE, v); chk("R9 external first", v, 32'h8000_000B);
    csr_wr(A_STATUS, 32'h0000_1808);
    @(negedge clk); irq_sw = 1'b1; irq_tmr = 1'b1;
    @(negedge clk); irq_sw = 1'b0; irq_tmr = 1'b0;
    csr_rd(A_CAUSE, v); chk("R9 software over timer", v, 32'h8000_0003);

    // R9 exception over return
    @(negedge clk); exc_valid = 1'b1; exc_cause = 4'd3; mret_req = 1'b1;
    #1 chk("R9 exception over return", redirect_pc, 32'h2000);
    @(negedge clk); exc_valid = 1'b0; mret_req = 1'b0;
    csr_rd(A_CAUSE, v); chk("R9 cause after collision", v, 32'd3);

    // R11 write blocked during trap
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 4'd2;
    csr_valid = 1'b1; csr_we = 1'b1; csr_addr = A_SCRATCH; csr_wdata = 32'hDEAD_BEEF;
    #1 chk("R11 ready low", {31'd0, csr_ready}, 0);
    @(negedge clk); exc_valid = 1'b0; csr_valid = 1'b0; csr_we = 1'b0;
    csr_rd(A_SCRATCH, v); chk("R11 blocked write ignored", v, 0);
    csr_wr(A_SCRATCH, 32'h1234_5678);
    csr_rd(A_SCRATCH, v); chk("R10 scratch store", v, 32'h1234_5678);

    // R13 illegal saved privilege
    csr_wr(A_STATUS, 32'h0000_0888);
    csr_rd(A_STATUS, v); chk("R13 illegal priv ignored", v, 32'h1888);
    csr_rd(12'h7C0, v);  chk("R10 unmapped reads zero", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule